// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block is the programmer-visible register storage for an 8-bit processor core. It holds two copies of the working registers: a main copy and an alternate copy. Each copy has an accumulator, a flag byte and six general-purpose bytes, and the general-purpose bytes also pair up into three 16-bit registers. Two exchange strobes choose which copy the datapath sees. One strobe swaps only the accumulator and flags. The other swaps only the general-purpose set. A swap flips a one-bit selector and copies no data. Beside the banked storage sit registers that have no second copy: a 16-bit stack pointer, two 16-bit index registers, a 16-bit program counter, an 8-bit interrupt-page register and an 8-bit refresh register.

The decode logic drives two independent combinational read ports and one write port. Each port carries a width flag that picks byte access or 16-bit access. Reads show the registered contents, so a value written in one cycle can be read in the next. Instruction decode, the ALU and the bus logic are outside this block.

Top module: `dual_bank_regfile`

## Requirements
- R1: A byte access (wide flag 0) uses these select codes: 0..5 are the general-purpose bytes of the visible set (even code = high half of pair code/2, odd code = low half), 6 is the accumulator, 7 is the flags, 8 is the interrupt page and 9 is refresh. A byte write stores wr_data[7:0], and a byte read returns the register in bits 7:0 with bits 15:8 zero.
- R2: A 16-bit access (wide flag 1) uses these select codes: 0..2 are the general-purpose pairs, 3 is accumulator:flags, 4 is the stack pointer, 5 and 6 are the two index registers and 7 is the program counter. A pair read returns the high byte in 15:8 and the low byte in 7:0, and a pair write updates both halves in the same cycle.
- R3: A pulse on xchg_gp toggles gp_alt. The two general-purpose sets hold separate contents, and switching between them copies no data.
- R4: A pulse on xchg_af toggles af_alt and selects the other accumulator/flag set. It does not change gp_alt or the general-purpose contents, and xchg_gp does not change af_alt.
- R5: The stack pointer, both index registers and the program counter have no second copy, so their contents read the same in every bank selection.
- R6: A read of a register that is being written in the same cycle returns the old value, and the new value appears from the next cycle.
- R7: When an exchange strobe and a write occur in the same cycle, the write lands in the bank that was visible before the swap.
- R8: Reset (rst_n low, asynchronous) sets af_alt and gp_alt to 0 (main bank) and sets the program counter to zero.
- R9: Select codes outside the R1/R2 maps read as zero, and writes to them change no register.
- R10: The two read ports operate independently and can return different registers in the same cycle.
- R11: The interrupt-page and refresh bytes have no second copy and keep their contents across both exchanges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xchg_af | input | 1 | Swap the visible accumulator/flag set |
| xchg_gp | input | 1 | Swap the visible general-purpose set |
| wr_en | input | 1 | Write enable |
| wr_wide | input | 1 | Write width: 0 byte, 1 sixteen bits |
| wr_sel | input | SEL_W | Write select code |
| wr_data | input | 2*BYTE_W | Write data |
| rd0_wide | input | 1 | Read port 0 width |
| rd0_sel | input | SEL_W | Read port 0 select code |
| rd0_data | output | 2*BYTE_W | Read port 0 data |
| rd1_wide | input | 1 | Read port 1 width |
| rd1_sel | input | SEL_W | Read port 1 select code |
| rd1_data | output | 2*BYTE_W | Read port 1 data |
| af_alt | output | 1 | 1 when the alternate accumulator/flag set is visible |
| gp_alt | output | 1 | 1 when the alternate general-purpose set is visible |

## Verification
The bench builds the block with its defaults: BYTE_W of 8, GP_PAIRS of 3 and SEL_W of 4. With these values every one of the sixteen select codes in both widths can be swept on both read ports. The bench repeats the sweep in all four combinations of the two bank selectors, so the unused codes and every banked or unbanked register are compared against an arithmetic model. The small code space also makes it cheap to aim a write at each pair and at the same-cycle collisions of read with write and of exchange with write.

// File: rtl/rf_pkg.sv
package rf_pkg;
   // number of byte registers reachable through the byte map
   function automatic int byte_codes(input int pairs);
      return 2 * pairs + 4;
   endfunction
   // number of registers reachable through the wide map
   function automatic int wide_codes(input int pairs);
      return pairs + 5;
   endfunction
   localparam int N_WORDS    = 4;   // stack pointer, two index registers, program counter
   localparam int PC_WORD    = 3;
   localparam int N_PLAIN_B  = 2;   // interrupt page, refresh
endpackage

// File: rtl/rf_toggle_sel.sv
module rf_toggle_sel (
   input  logic clk,
   input  logic rst_n,
   input  logic flip,
   output logic sel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sel <= 1'b0;
      else if (flip) sel <= ~sel;
   end
endmodule

// File: rtl/rf_bank_store.sv
module rf_bank_store #(
   parameter int BYTE_W = 8,
   parameter int NREG   = 6
) (
   input  logic                           clk,
   input  logic                           bank_sel,
   input  logic [NREG-1:0]                wr_mask,
   input  logic [NREG-1:0][BYTE_W-1:0]    wr_val,
   output logic [NREG-1:0][BYTE_W-1:0]    rd_q
);
   logic [NREG-1:0][BYTE_W-1:0] mem_main;
   logic [NREG-1:0][BYTE_W-1:0] mem_alt;

   always_ff @(posedge clk) begin
      for (int r = 0; r < NREG; r++) begin
         if (wr_mask[r] && !bank_sel) mem_main[r] <= wr_val[r];
         if (wr_mask[r] &&  bank_sel) mem_alt[r]  <= wr_val[r];
      end
   end

   assign rd_q = bank_sel ? mem_alt : mem_main;
endmodule

// File: rtl/rf_word_store.sv
module rf_word_store #(
   parameter int              W       = 16,
   parameter int              NWORD   = 4,
   parameter bit              HAS_RST = 1'b0,
   parameter int              RST_IDX = 0,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NWORD-1:0]         wr_mask,
   input  logic [NWORD-1:0][W-1:0]  wr_val,
   output logic [NWORD-1:0][W-1:0]  rd_q
);
   for (genvar i = 0; i < NWORD; i++) begin : g_word
      logic [W-1:0] word_q;
      if (HAS_RST && i == RST_IDX) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          word_q <= RST_VAL;
            else if (wr_mask[i]) word_q <= wr_val[i];
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (wr_mask[i]) word_q <= wr_val[i];
         end
      end
      assign rd_q[i] = word_q;
   end
endmodule

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
   parameter int BYTE_W   = 8,
   parameter int GP_PAIRS = 3,
   parameter int SEL_W    = 4,
   localparam int NGP     = 2 * GP_PAIRS,
   localparam int WW      = 2 * BYTE_W
) (
   input  logic                                    wr_en,
   input  logic                                    wr_wide,
   input  logic [SEL_W-1:0]                        wr_sel,
   input  logic [WW-1:0]                           wr_data,
   output logic [NGP-1:0]                          gp_mask,
   output logic [NGP-1:0][BYTE_W-1:0]              gp_val,
   output logic [1:0]                              af_mask,
   output logic [1:0][BYTE_W-1:0]                  af_val,
   output logic [rf_pkg::N_WORDS-1:0]              wd_mask,
   output logic [rf_pkg::N_WORDS-1:0][WW-1:0]      wd_val,
   output logic [rf_pkg::N_PLAIN_B-1:0]            bt_mask,
   output logic [rf_pkg::N_PLAIN_B-1:0][BYTE_W-1:0] bt_val
);
   logic [BYTE_W-1:0] hi_b, lo_b;
   int c;
   assign hi_b = wr_data[WW-1:BYTE_W];
   assign lo_b = wr_data[BYTE_W-1:0];

   always_comb begin
      c       = int'(wr_sel);
      gp_mask = '0;
      af_mask = '0;
      wd_mask = '0;
      bt_mask = '0;
      for (int i = 0; i < NGP; i++)
         gp_val[i] = (wr_wide && (i % 2 == 0)) ? hi_b : lo_b;
      af_val[0] = wr_wide ? hi_b : lo_b;
      af_val[1] = lo_b;
      for (int i = 0; i < rf_pkg::N_WORDS; i++)   wd_val[i] = wr_data;
      for (int i = 0; i < rf_pkg::N_PLAIN_B; i++) bt_val[i] = lo_b;
      if (wr_en) begin
         if (!wr_wide) begin
            for (int i = 0; i < NGP; i++)
               if (c == i) gp_mask[i] = 1'b1;
            if (c == NGP)     af_mask[0] = 1'b1;
            if (c == NGP + 1) af_mask[1] = 1'b1;
            for (int i = 0; i < rf_pkg::N_PLAIN_B; i++)
               if (c == NGP + 2 + i) bt_mask[i] = 1'b1;
         end else begin
            for (int i = 0; i < GP_PAIRS; i++)
               if (c == i) begin
                  gp_mask[2*i]   = 1'b1;
                  gp_mask[2*i+1] = 1'b1;
               end
            if (c == GP_PAIRS) af_mask = 2'b11;
            for (int i = 0; i < rf_pkg::N_WORDS; i++)
               if (c == GP_PAIRS + 1 + i) wd_mask[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
   parameter int BYTE_W   = 8,
   parameter int GP_PAIRS = 3,
   parameter int SEL_W    = 4,
   localparam int NGP     = 2 * GP_PAIRS,
   localparam int WW      = 2 * BYTE_W
) (
   input  logic                                     wide,
   input  logic [SEL_W-1:0]                         sel,
   input  logic [NGP-1:0][BYTE_W-1:0]               gp_q,
   input  logic [1:0][BYTE_W-1:0]                   af_q,
   input  logic [rf_pkg::N_WORDS-1:0][WW-1:0]       wd_q,
   input  logic [rf_pkg::N_PLAIN_B-1:0][BYTE_W-1:0] bt_q,
   output logic [WW-1:0]                            data
);
   logic [BYTE_W-1:0] byte_v;
   int c;

   always_comb begin
      c      = int'(sel);
      byte_v = '0;
      data   = '0;
      if (!wide) begin
         for (int i = 0; i < NGP; i++)
            if (c == i) byte_v = gp_q[i];
         if (c == NGP)     byte_v = af_q[0];
         if (c == NGP + 1) byte_v = af_q[1];
         for (int i = 0; i < rf_pkg::N_PLAIN_B; i++)
            if (c == NGP + 2 + i) byte_v = bt_q[i];
         data = {{BYTE_W{1'b0}}, byte_v};
      end else begin
         for (int i = 0; i < GP_PAIRS; i++)
            if (c == i) data = {gp_q[2*i], gp_q[2*i+1]};
         if (c == GP_PAIRS) data = {af_q[0], af_q[1]};
         for (int i = 0; i < rf_pkg::N_WORDS; i++)
            if (c == GP_PAIRS + 1 + i) data = wd_q[i];
      end
   end
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile #(
   parameter int BYTE_W   = 8,
   parameter int GP_PAIRS = 3,
   parameter int SEL_W    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  xchg_af,
   input  logic                  xchg_gp,
   input  logic                  wr_en,
   input  logic                  wr_wide,
   input  logic [SEL_W-1:0]      wr_sel,
   input  logic [2*BYTE_W-1:0]   wr_data,
   input  logic                  rd0_wide,
   input  logic [SEL_W-1:0]      rd0_sel,
   output logic [2*BYTE_W-1:0]   rd0_data,
   input  logic                  rd1_wide,
   input  logic [SEL_W-1:0]      rd1_sel,
   output logic [2*BYTE_W-1:0]   rd1_data,
   output logic                  af_alt,
   output logic                  gp_alt
);
   localparam int NGP    = 2 * GP_PAIRS;
   localparam int WW     = 2 * BYTE_W;
   localparam int N_RD   = 2;
   localparam int MAXCOD = (rf_pkg::byte_codes(GP_PAIRS) > rf_pkg::wide_codes(GP_PAIRS))
                           ? rf_pkg::byte_codes(GP_PAIRS) : rf_pkg::wide_codes(GP_PAIRS);

   if (BYTE_W < 1) begin : g_bad_width
      $error("BYTE_W must be at least 1");
   end
   if (GP_PAIRS < 1) begin : g_bad_pairs
      $error("GP_PAIRS must be at least 1");
   end
   if ((1 << SEL_W) < MAXCOD) begin : g_bad_sel
      $error("SEL_W too narrow for the register map");
   end

   logic [NGP-1:0]                          gp_mask;
   logic [NGP-1:0][BYTE_W-1:0]              gp_val, gp_q;
   logic [1:0]                              af_mask;
   logic [1:0][BYTE_W-1:0]                  af_val, af_q;
   logic [rf_pkg::N_WORDS-1:0]              wd_mask;
   logic [rf_pkg::N_WORDS-1:0][WW-1:0]      wd_val, wd_q;
   logic [rf_pkg::N_PLAIN_B-1:0]            bt_mask;
   logic [rf_pkg::N_PLAIN_B-1:0][BYTE_W-1:0] bt_val, bt_q;

   rf_toggle_sel u_af_sel (.clk(clk), .rst_n(rst_n), .flip(xchg_af), .sel(af_alt));
   rf_toggle_sel u_gp_sel (.clk(clk), .rst_n(rst_n), .flip(xchg_gp), .sel(gp_alt));

   rf_wr_decode #(.BYTE_W(BYTE_W), .GP_PAIRS(GP_PAIRS), .SEL_W(SEL_W)) u_dec (
      .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_data(wr_data),
      .gp_mask(gp_mask), .gp_val(gp_val), .af_mask(af_mask), .af_val(af_val),
      .wd_mask(wd_mask), .wd_val(wd_val), .bt_mask(bt_mask), .bt_val(bt_val)
   );

   rf_bank_store #(.BYTE_W(BYTE_W), .NREG(NGP)) u_gp (
      .clk(clk), .bank_sel(gp_alt), .wr_mask(gp_mask), .wr_val(gp_val), .rd_q(gp_q)
   );
   rf_bank_store #(.BYTE_W(BYTE_W), .NREG(2)) u_af (
      .clk(clk), .bank_sel(af_alt), .wr_mask(af_mask), .wr_val(af_val), .rd_q(af_q)
   );

   rf_word_store #(.W(WW), .NWORD(rf_pkg::N_WORDS), .HAS_RST(1'b1),
                   .RST_IDX(rf_pkg::PC_WORD), .RST_VAL('0)) u_words (
      .clk(clk), .rst_n(rst_n), .wr_mask(wd_mask), .wr_val(wd_val), .rd_q(wd_q)
   );
   rf_word_store #(.W(BYTE_W), .NWORD(rf_pkg::N_PLAIN_B), .HAS_RST(1'b0),
                   .RST_IDX(0), .RST_VAL('0)) u_bytes (
      .clk(clk), .rst_n(rst_n), .wr_mask(bt_mask), .wr_val(bt_val), .rd_q(bt_q)
   );

   logic [N_RD-1:0]            rp_wide;
   logic [N_RD-1:0][SEL_W-1:0] rp_sel;
   logic [N_RD-1:0][WW-1:0]    rp_data;

   assign rp_wide  = {rd1_wide, rd0_wide};
   assign rp_sel   = {rd1_sel, rd0_sel};
   assign rd0_data = rp_data[0];
   assign rd1_data = rp_data[1];

   for (genvar p = 0; p < N_RD; p++) begin : g_rd
      rf_read_port #(.BYTE_W(BYTE_W), .GP_PAIRS(GP_PAIRS), .SEL_W(SEL_W)) u_port (
         .wide(rp_wide[p]), .sel(rp_sel[p]), .gp_q(gp_q), .af_q(af_q),
         .wd_q(wd_q), .bt_q(bt_q), .data(rp_data[p])
      );
   end
endmodule

// File: rtl/dual_bank_regfile_chk.sv
module dual_bank_regfile_chk #(
   parameter int BYTE_W   = 8,
   parameter int GP_PAIRS = 3,
   parameter int SEL_W    = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                xchg_af,
   input logic                xchg_gp,
   input logic                wr_en,
   input logic                wr_wide,
   input logic [SEL_W-1:0]    wr_sel,
   input logic [2*BYTE_W-1:0] wr_data,
   input logic                rd0_wide,
   input logic [SEL_W-1:0]    rd0_sel,
   input logic [2*BYTE_W-1:0] rd0_data,
   input logic                af_alt,
   input logic                gp_alt
);
   localparam logic [SEL_W-1:0] PC_CODE   = SEL_W'(GP_PAIRS + 4);
   localparam logic [SEL_W-1:0] LAST_BYTE = SEL_W'(2 * GP_PAIRS + 3);
   localparam logic [SEL_W-1:0] PAIR0     = '0;

   logic rd_pc, wr_pc, rd_p0, wr_p0, rd_unused;
   assign rd_pc     = rd0_wide && rd0_sel == PC_CODE;
   assign wr_pc     = wr_en && wr_wide && wr_sel == PC_CODE;
   assign rd_p0     = rd0_wide && rd0_sel == PAIR0;
   assign wr_p0     = wr_en && wr_wide && wr_sel == PAIR0;
   assign rd_unused = rd0_wide ? (rd0_sel > PC_CODE) : (rd0_sel > LAST_BYTE);

   // R8: selectors return to the main bank under reset
   a_r8_sel_reset: assert property (@(posedge clk)
      !rst_n |=> (!af_alt && !gp_alt));

   a_r3_gp_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      xchg_gp |=> (gp_alt != $past(gp_alt)));

   a_r4_gp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !xchg_gp |=> $stable(gp_alt));

   a_r4_af_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      xchg_af |=> (af_alt != $past(af_alt)));

   a_r4_af_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !xchg_af |=> $stable(af_alt));

   a_r2_pair_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_p0 && !xchg_gp) |=> (!rd_p0 || rd0_data == $past(wr_data)));

   a_r5_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pc && !wr_pc) |=> (!rd_pc || $stable(rd0_data)));

   a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_unused |-> (rd0_data == '0));
endmodule

bind dual_bank_regfile dual_bank_regfile_chk #(
   .BYTE_W(BYTE_W), .GP_PAIRS(GP_PAIRS), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/dual_bank_regfile_test.sv
module dual_bank_regfile_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xchg_af = 1'b0, xchg_gp = 1'b0;
   logic        wr_en = 1'b0, wr_wide = 1'b0;
   logic [3:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic        rd0_wide = 1'b0, rd1_wide = 1'b0;
   logic [3:0]  rd0_sel = '0, rd1_sel = '0;
   logic [15:0] rd0_data, rd1_data;
   logic        af_alt, gp_alt;

   int total = 0, bad = 0;
   bit done = 0;

   logic [7:0]  m_gp [2][6];
   logic [7:0]  m_af [2][2];
   logic [15:0] m_w  [4];
   logic [7:0]  m_ip, m_rf;
   bit          ma = 0, mg = 0;

   dual_bank_regfile uut (
      .clk(clk), .rst_n(rst_n), .xchg_af(xchg_af), .xchg_gp(xchg_gp),
      .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd0_wide(rd0_wide), .rd0_sel(rd0_sel), .rd0_data(rd0_data),
      .rd1_wide(rd1_wide), .rd1_sel(rd1_sel), .rd1_data(rd1_data),
      .af_alt(af_alt), .gp_alt(gp_alt)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [15:0] exp_rd(input bit wide, input int c);
      if (!wide) begin
         if (c < 6)  return {8'h00, m_gp[mg][c]};
         if (c == 6) return {8'h00, m_af[ma][0]};
         if (c == 7) return {8'h00, m_af[ma][1]};
         if (c == 8) return {8'h00, m_ip};
         if (c == 9) return {8'h00, m_rf};
         return 16'h0000;
      end
      if (c < 3)  return {m_gp[mg][2*c], m_gp[mg][2*c+1]};
      if (c == 3) return {m_af[ma][0], m_af[ma][1]};
      if (c < 8)  return m_w[c-4];
      return 16'h0000;
   endfunction

   function automatic string tag_of(input bit wide, input int c);
      if (!wide) begin
         if (c < 6)  return "R1";
         if (c < 8)  return "R4";
         if (c < 10) return "R11";
         return "R9";
      end
      if (c < 3) return "R2";
      if (c == 3) return "R4";
      if (c < 8) return "R5";
      return "R9";
   endfunction

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // drive one cycle; model applies write to the pre-swap bank, then swaps
   task automatic cyc(input bit we, input bit wide, input int s, input logic [15:0] d,
                      input bit xa, input bit xg);
      wr_en = we; wr_wide = wide; wr_sel = 4'(s); wr_data = d;
      xchg_af = xa; xchg_gp = xg;
      @(posedge clk);
      if (we) begin
         if (!wide) begin
            if (s < 6) m_gp[mg][s] = d[7:0];
            else if (s == 6) m_af[ma][0] = d[7:0];
            else if (s == 7) m_af[ma][1] = d[7:0];
            else if (s == 8) m_ip = d[7:0];
            else if (s == 9) m_rf = d[7:0];
         end else begin
            if (s < 3) begin m_gp[mg][2*s] = d[15:8]; m_gp[mg][2*s+1] = d[7:0]; end
            else if (s == 3) begin m_af[ma][0] = d[15:8]; m_af[ma][1] = d[7:0]; end
            else if (s < 8) m_w[s-4] = d;
         end
      end
      if (xa) ma = !ma;
      if (xg) mg = !mg;
      #1;
      wr_en = 0; xchg_af = 0; xchg_gp = 0;
   endtask

   task automatic sweep_all();
      for (int w = 0; w < 2; w++)
         for (int c = 0; c < 16; c++) begin
            rd0_wide = w[0]; rd0_sel = 4'(c);
            rd1_wide = w[0]; rd1_sel = 4'(15 - c);
            #1;
            chk(tag_of(w[0], c), rd0_data, exp_rd(w[0], c));
            chk(tag_of(w[0], 15 - c), rd1_data, exp_rd(w[0], 15 - c));
         end
   endtask

   initial begin
      // R8: reset state
      repeat (3) @(posedge clk);
      #1;
      rd0_wide = 1; rd0_sel = 4'd7;
      #1;
      chk("R8", {15'd0, af_alt}, 16'd0);
      chk("R8", {15'd0, gp_alt}, 16'd0);
      chk("R8", rd0_data, 16'h0000);
      m_w[3] = 16'h0000;
      rst_n = 1;
      @(posedge clk); #1;

      cyc(1, 1, 4, 16'hFFF0, 0, 0);
      cyc(1, 1, 5, 16'h4000, 0, 0);
      cyc(1, 1, 6, 16'h5000, 0, 0);

      // R3/R4: all four bank combinations, fill and check everything
      for (int b = 0; b < 4; b++) begin
         cyc(0, 0, 0, 16'h0, b[0] != ma, b[1] != mg);
         chk("R4", {15'd0, af_alt}, {15'd0, b[0]});
         chk("R3", {15'd0, gp_alt}, {15'd0, b[1]});
         for (int c = 0; c < 10; c++)
            cyc(1, 0, c, 16'(((c * 37 + b * 11 + 5) & 8'hFF) | 16'hAB00), 0, 0);
         sweep_all();
      end
      // R3: swapping back exposes the earlier main contents untouched
      cyc(0, 0, 0, 16'h0, 1, 1);
      chk("R3", {15'd0, gp_alt}, 16'd0);
      sweep_all();

      // R2: 16-bit writes to every wide code, halves checked through byte reads
      for (int c = 0; c < 8; c++) begin
         cyc(1, 1, c, 16'(16'h1234 + c * 16'h0F1), 0, 0);
         rd0_wide = 1; rd0_sel = 4'(c); #1;
         chk("R2", rd0_data, 16'(16'h1234 + c * 16'h0F1));
         if (c < 3) begin
            rd0_wide = 0; rd0_sel = 4'(2*c); rd1_wide = 0; rd1_sel = 4'(2*c+1); #1;
            chk("R2", rd0_data, {8'h00, 8'((16'h1234 + c * 16'h0F1) >> 8)});
            chk("R2", rd1_data, {8'h00, 8'(16'h1234 + c * 16'h0F1)});
         end
      end

      // R1: byte read zero-extends
      cyc(1, 0, 2, 16'hFF3C, 0, 0);
      rd0_wide = 0; rd0_sel = 4'd2; #1;
      chk("R1", rd0_data, 16'h003C);

      // R6: read during write returns old, then new
      rd0_wide = 0; rd0_sel = 4'd0;
      wr_en = 1; wr_wide = 0; wr_sel = 4'd0; wr_data = 16'h00A5;
      #1;
      chk("R6", rd0_data, {8'h00, m_gp[mg][0]});
      cyc(1, 0, 0, 16'h00A5, 0, 0);
      rd0_wide = 0; rd0_sel = 4'd0; #1;
      chk("R6", rd0_data, 16'h00A5);

      // R7: exchange and write in the same cycle
      cyc(1, 0, 1, 16'h005C, 0, 1);
      rd0_wide = 0; rd0_sel = 4'd1; #1;
      chk("R7", rd0_data, exp_rd(0, 1));
      cyc(1, 0, 6, 16'h0077, 1, 0);
      rd0_wide = 0; rd0_sel = 4'd6; #1;
      chk("R7", rd0_data, exp_rd(0, 6));
      cyc(0, 0, 0, 16'h0, 1, 1);
      rd0_wide = 0; rd0_sel = 4'd1; rd1_wide = 0; rd1_sel = 4'd6; #1;
      chk("R7", rd0_data, 16'h005C);
      chk("R7", rd1_data, 16'h0077);

      // R9: writes to unused codes change nothing
      for (int c = 10; c < 16; c++) cyc(1, 0, c, 16'hDEAD, 0, 0);
      for (int c = 8; c < 16; c++)  cyc(1, 1, c, 16'hBEEF, 0, 0);
      sweep_all();

      // R10: two ports, different registers, same cycle
      rd0_wide = 1; rd0_sel = 4'd4; rd1_wide = 0; rd1_sel = 4'd8; #1;
      chk("R10", rd0_data, m_w[0]);
      chk("R10", rd1_data, {8'h00, m_ip});

      // R5/R11: unbanked registers survive both exchanges
      cyc(0, 0, 0, 16'h0, 1, 1);
      rd0_wide = 1; rd0_sel = 4'd7; rd1_wide = 0; rd1_sel = 4'd9; #1;
      chk("R5", rd0_data, m_w[3]);
      chk("R11", rd1_data, {8'h00, m_rf});

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule